// File: doc/BRIEF.md
# Cache Preload Line Sequencer

This block takes one preload request: a byte address, a byte length and a lock flag. It turns the byte range into a run of cache-line addresses and walks those lines one per clock, in ascending address order. The walk has two passes over the same run.

The first pass asks the outstanding-request tracker whether each line collides with work already in flight. If any line collides, the block hands the whole request back for requeue and changes nothing. Otherwise the second pass looks up each line in the tag store. On a hit, the block sets the line's lock bit when the lock flag was given. On a miss, it allocates a wait entry so that the memory side fetches the line.

The tag arrays, the fetch machinery and replacement all sit outside the block. They are reached through single-cycle query and strobe ports.

Top module: `preload_seq`

## Requirements
- R1: A request length of zero is handled as a one-byte request, so exactly one line is walked.
- R2: The number of lines walked is 1 + (offset + length − 1) / LINE_BYTES, where offset is the address modulo LINE_BYTES.
- R3: Line k of a request has address (request address with its low log2(LINE_BYTES) bits cleared) + k·LINE_BYTES. Lines are presented in increasing k, one per clock, in each pass.
- R4: Every line of the request is presented on the conflict port before any line is presented on the tag port. No tag lookup, lock or miss strobe occurs during the conflict pass.
- R5: If `conflictHit` is high for any line, `reqRequeue` is high in that cycle. No tag, lock or miss strobe follows, and the block is idle (`reqReady` high) in the next cycle.
- R6: In the tag pass, a line with `tagHit` high raises `lockValid` with `lockAddr` equal to that line if and only if the request's lock flag was set.
- R7: In the tag pass, a line with `tagHit` low raises `missValid` with `missAddr` equal to that line and `missLock` equal to the request's lock flag. `lockValid` stays low for that line.
- R8: A request presented while `cacheEnable` is low or `reqNonCache` is high is dropped. It raises no port strobe and leaves `reqReady` high.
- R9: `done` is high exactly in the cycle of the last line of the tag pass. The block is idle in the following cycle.
- R10: `reqReady` is high only while idle. `reqValid` is ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheEnable | input | 1 | Cache globally enabled |
| reqValid | input | 1 | Preload request present |
| reqAddr | input | ADDR_W | Request byte address |
| reqLen | input | LEN_W | Request byte length (0 means 1) |
| reqLock | input | 1 | Lock lines that hit |
| reqNonCache | input | 1 | Request address is non-cacheable |
| reqReady | output | 1 | Sequencer idle; request taken on this cycle's edge |
| reqRequeue | output | 1 | Request collided; caller must requeue it |
| conflictValid | output | 1 | Conflict query strobe |
| conflictAddr | output | ADDR_W | Line address under conflict query |
| conflictHit | input | 1 | Queried line collides with a pending request |
| tagValid | output | 1 | Tag lookup strobe |
| tagAddr | output | ADDR_W | Line address under tag lookup |
| tagHit | input | 1 | Looked-up line is resident |
| lockValid | output | 1 | Set the lock bit of the looked-up line |
| lockAddr | output | ADDR_W | Line to lock |
| missValid | output | 1 | Allocate a wait entry for a missing line |
| missAddr | output | ADDR_W | Line to fetch |
| missLock | output | 1 | Fetched line is to be locked |
| done | output | 1 | Last line of the tag pass is being handled |

## Verification
A request is taken on the clock edge where `reqValid` meets `reqReady`. For an N-line request, conflict line k is on the ports in the k+1-th cycle after that edge, and tag line k is on the ports in cycle N+k+1. `done` shares the cycle of tag line N−1, and `reqReady` returns one cycle later. A requeue is visible in the cycle of the colliding line, with `reqReady` back in the next cycle. The bench computes N and every line address from the request. It compares each of those cycles at the falling edge, with lookup hits supplied by a fixed parity function of the tag address. It sweeps every offset and length of a small line configuration, and places a collision on each line of several multi-line requests.

// File: rtl/preload_seq_pkg.sv
package preload_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CHECK = 2'd1,
    SEQ_PROBE = 2'd2
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture request, line index to zero
    logic step;    // move to the next line
    logic rewind;  // back to line zero for the tag pass
  } seqStrobe_t;

endpackage

// File: rtl/preload_seq_datapath.sv
module preload_seq_datapath
  import preload_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,  // power of two, at least 2
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqLock,
  output logic [ADDR_W-1:0] curAddr,
  output logic              isLast,
  output logic              lockFlag
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int SPAN_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;

  logic [SPAN_W-1:0] offExt, lenEff, span, lastNext;
  logic [LINE_W-1:0] baseLine, idxLine;
  logic [SPAN_W-1:0] lastIdx, idx;

  // Last line index of the byte range, with zero length treated as one byte.
  always_comb begin
    offExt   = SPAN_W'(reqAddr[OFF_W-1:0]);
    lenEff   = (reqLen == '0) ? SPAN_W'(1) : SPAN_W'(reqLen);
    span     = offExt + lenEff - SPAN_W'(1);
    lastNext = span >> OFF_W;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLine <= '0;
      lastIdx  <= '0;
      idx      <= '0;
      lockFlag <= 1'b0;
    end else if (strobe.load) begin
      baseLine <= reqAddr[ADDR_W-1:OFF_W];
      lastIdx  <= lastNext;
      idx      <= '0;
      lockFlag <= reqLock;
    end else if (strobe.rewind) begin
      idx <= '0;
    end else if (strobe.step) begin
      idx <= idx + SPAN_W'(1);
    end
  end

  assign idxLine = LINE_W'(idx);
  assign curAddr = {baseLine + idxLine, {OFF_W{1'b0}}};
  assign isLast  = (idx == lastIdx);

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> curAddr == ADDR_W'($past(curAddr) + LINE_BYTES));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/preload_seq_ctrl.sv
module preload_seq_ctrl
  import preload_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cacheEnable,
  input  logic       reqNonCache,
  input  logic       isLast,
  input  logic       lockFlag,
  input  logic       conflictHit,
  input  logic       tagHit,
  output seqStrobe_t strobe,
  output logic       reqReady,
  output logic       reqRequeue,
  output logic       conflictValid,
  output logic       tagValid,
  output logic       lockValid,
  output logic       missValid,
  output logic       done
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    reqReady      = 1'b0;
    reqRequeue    = 1'b0;
    conflictValid = 1'b0;
    tagValid      = 1'b0;
    lockValid     = 1'b0;
    missValid     = 1'b0;
    done          = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        reqReady = 1'b1;
        if (reqValid && cacheEnable && !reqNonCache) begin
          strobe.load = 1'b1;
          stateNext   = SEQ_CHECK;
        end
      end
      SEQ_CHECK: begin
        conflictValid = 1'b1;
        if (conflictHit) begin
          reqRequeue = 1'b1;
          stateNext  = SEQ_IDLE;
        end else if (isLast) begin
          strobe.rewind = 1'b1;
          stateNext     = SEQ_PROBE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      SEQ_PROBE: begin
        tagValid  = 1'b1;
        lockValid = tagHit && lockFlag;
        missValid = !tagHit;
        if (isLast) begin
          done      = 1'b1;
          stateNext = SEQ_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  // R4
  probe_after_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tagValid) |-> $past(conflictValid) && !$past(conflictHit));

  // R5
  requeue_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqRequeue |=> reqReady && !tagValid);

  // R7
  miss_no_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> !lockValid && tagValid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

endmodule

// File: rtl/preload_seq.sv
module preload_seq
  import preload_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEnable,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqLock,
  input  logic              reqNonCache,
  output logic              reqReady,
  output logic              reqRequeue,
  output logic              conflictValid,
  output logic [ADDR_W-1:0] conflictAddr,
  input  logic              conflictHit,
  output logic              tagValid,
  output logic [ADDR_W-1:0] tagAddr,
  input  logic              tagHit,
  output logic              lockValid,
  output logic [ADDR_W-1:0] lockAddr,
  output logic              missValid,
  output logic [ADDR_W-1:0] missAddr,
  output logic              missLock,
  output logic              done
);
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] curAddr;
  logic              isLast, lockFlag;

  preload_seq_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .cacheEnable, .reqNonCache,
    .isLast, .lockFlag, .conflictHit, .tagHit,
    .strobe, .reqReady, .reqRequeue, .conflictValid, .tagValid,
    .lockValid, .missValid, .done
  );

  preload_seq_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
  ) u_dp (
    .clk, .rstN, .strobe, .reqAddr, .reqLen, .reqLock,
    .curAddr, .isLast, .lockFlag
  );

  assign conflictAddr = curAddr;
  assign tagAddr      = curAddr;
  assign lockAddr     = curAddr;
  assign missAddr     = curAddr;
  assign missLock     = lockFlag;

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (conflictValid || tagValid) |-> !reqReady);

endmodule

// File: tb/preload_seq_bench.sv
`timescale 1ns/1ps
module preload_seq_bench;
  localparam int AW = 10;
  localparam int LB = 8;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cacheEnable = 1'b1;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic reqLock = 1'b0;
  logic reqNonCache = 1'b0;
  logic reqReady, reqRequeue, conflictValid, tagValid, lockValid, missValid, missLock, done;
  logic [AW-1:0] conflictAddr, tagAddr, lockAddr, missAddr;
  logic conflictHit, tagHit;
  logic trapOn = 1'b0;
  logic [AW-1:0] trapAddr = '0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // Residency model: parity of line-address bits 5..3.
  assign tagHit      = tagValid && (^tagAddr[5:3]);
  assign conflictHit = trapOn && conflictValid && (conflictAddr == trapAddr);

  preload_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .LEN_W(LW)) u_preload_seq (
    .clk, .rstN, .cacheEnable, .reqValid, .reqAddr, .reqLen, .reqLock,
    .reqNonCache, .reqReady, .reqRequeue, .conflictValid, .conflictAddr,
    .conflictHit, .tagValid, .tagAddr, .tagHit, .lockValid, .lockAddr,
    .missValid, .missAddr, .missLock, .done
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleChk(input string tag);
    chk(reqReady == 1'b1, tag, int'(reqReady), 1);
    chk(!conflictValid && !tagValid && !lockValid && !missValid && !done && !reqRequeue,
        tag, int'({conflictValid, tagValid, lockValid, missValid, done, reqRequeue}), 0);
  endtask

  // trapIdx < 0: no collision. noise: hold reqValid with junk while busy.
  task automatic runReq(input int addr, input int len, input bit lock,
                        input int trapIdx, input bit noise);
    int off, le, n, base, la;
    string tagN;
    off  = addr % LB;
    le   = (len == 0) ? 1 : len;
    n    = 1 + (off + le - 1) / LB;
    base = addr - off;
    tagN = (len == 0) ? "R1" : "R2";
    if (trapIdx >= 0) begin
      trapOn   = 1'b1;
      trapAddr = AW'(base + trapIdx * LB);
    end else trapOn = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = AW'(addr); reqLen = LW'(len); reqLock = lock;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (noise) begin reqAddr = AW'(addr ^ 'h155); reqLen = LW'(len ^ 7); end
        else reqValid = 1'b0;
      end
      la = (base + i * LB) % (1 << AW);
      chk(!reqReady, "R10", int'(reqReady), 0);
      chk(conflictValid && int'(conflictAddr) == la, "R3", int'(conflictAddr), la);
      chk(!tagValid && !lockValid && !missValid, "R4",
          int'({tagValid, lockValid, missValid}), 0);
      if (i == trapIdx) begin
        chk(reqRequeue == 1'b1, "R5", int'(reqRequeue), 1);
        reqValid = 1'b0;
        @(negedge clk);
        idleChk("R5");
        trapOn = 1'b0;
        return;
      end
      chk(!reqRequeue && !done, tagN, int'({reqRequeue, done}), 0);
    end
    for (int i = 0; i < n; i++) begin
      bit hit;
      @(negedge clk);
      la  = (base + i * LB) % (1 << AW);
      hit = ^la[5:3];
      chk(tagValid && !conflictValid && int'(tagAddr) == la, "R3", int'(tagAddr), la);
      chk(lockValid == (hit && lock), "R6", int'(lockValid), int'(hit && lock));
      if (lockValid) chk(int'(lockAddr) == la, "R6", int'(lockAddr), la);
      chk(missValid == !hit, "R7", int'(missValid), int'(!hit));
      if (!hit) chk(int'(missAddr) == la && missLock == lock, "R7",
                    int'(missAddr), la);
      chk(done == (i == n - 1), "R9", int'(done), int'(i == n - 1));
      if (i == n - 1) reqValid = 1'b0;
    end
    @(negedge clk);
    idleChk(tagN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idleChk("R10");
    rstN = 1'b1;
    @(negedge clk);
    idleChk("R10");

    // R1 R2 R3 R6 R7 R9: every offset and length, both lock settings
    for (int l = 0; l < 2; l++)
      for (int off = 0; off < LB; off++)
        for (int len = 0; len < (1 << LW); len++)
          runReq(64 * ((off + len) % 12) + 8 * l + off, len, bit'(l), -1, 1'b0);

    // R5: collision on every line of multi-line requests
    for (int n = 1; n <= 4; n++)
      for (int k = 0; k < n; k++)
        runReq(200 + 3, 8 * (n - 1) + 2, 1'b1, k, 1'b0);

    // R10: request input held busy with junk values
    runReq(517, 27, 1'b1, -1, 1'b1);
    runReq(66, 13, 1'b0, 1, 1'b1);

    // R8: cache disabled, then non-cacheable address
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      cacheEnable = (m != 0); reqNonCache = (m != 0);
      reqValid = 1'b1; reqAddr = AW'(40); reqLen = LW'(20); reqLock = 1'b1;
      repeat (3) begin
        @(negedge clk);
        idleChk("R8");
      end
      reqValid = 1'b0; cacheEnable = 1'b1; reqNonCache = 1'b0;
    end
    runReq(8, 0, 1'b0, -1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule